// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the programmed-I/O read and write strobes for the two drives on one IDE/ATA channel. Each drive has its own timing set. Each set holds one timing byte for read cycles and one for write cycles. A small indexed register port lets the host choose which set later timing writes go to, and program the bytes in it. The same port gives access to a control byte that carries the address setup time, which both drives share. The control byte also carries a prefetch enable and a ready-delay field. A read-only slot on the port reports a bus clock speed strap.

A drive access starts with a one-cycle request that names the drive and the direction. The block loads the clock counts for that drive and direction from the registers. It then runs three phases: address setup, the active read or write pulse, and recovery. A one-cycle done pulse follows. While a cycle is in progress the block reports busy and ignores new requests. Timing values are captured when a request is accepted, so writes made while a cycle runs change only later cycles.

Top module: `pio_timing_gen`

## Requirements
- R1: After reset, every timing byte in both sets reads 0xFF (16-clock pulse, 17-clock recovery), the control byte reads 0x30 (4-clock setup, set A selected, prefetch off), and `addr_valid`, both strobes, `busy` and `done` are low.
- R2: Bit 0 of the control byte (index 3) selects set A (0) or set B (1). Writes and reads at index 0 (read timing) and index 1 (write timing) reach only the selected set. The other set keeps its contents.
- R3: The upper nibble of a timing byte encodes the active pulse as clocks minus 1, for 1 to 16 clocks.
- R4: The lower nibble of a timing byte encodes recovery as clocks minus 2, for 2 to 17 clocks.
- R5: Control byte bits [5:4] encode the address setup as clocks minus 1, for 1 to 4 clocks. Cycles to both drives use this same value.
- R6: Drive 0 uses set A and drive 1 uses set B. A read uses the set's index 0 byte and drives `rd_strobe`. A write uses the index 1 byte and drives `wr_strobe`.
- R7: After the request is accepted, `addr_valid` is high for the setup count, then the strobe for the pulse count, then all three are low for the recovery count, and then `done` is high for exactly one cycle.
- R8: `busy` is high from the cycle after acceptance until recovery ends. A request that arrives while `busy` is high is dropped. A request in the `done` cycle is accepted.
- R9: A timing byte written while a cycle runs does not change that cycle. It applies from the next accepted request.
- R10: Index 2 reads back the strap input in bit 0 (1 for a 25 MHz bus, 0 for 33 MHz), with the other bits zero. Writes to index 2 change no register.
- R11: Control byte bit 6 drives `prefetch_en`. Bits [2:1] hold a ready-delay code that reads back unchanged. Control bits 7 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register write index |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 2 | Register read index |
| reg_rdata | output | 8 | Register read data (combinational) |
| strap_25mhz | input | 1 | Bus speed strap, 1 = 25 MHz |
| req | input | 1 | Cycle request pulse |
| req_drive | input | 1 | Drive number for the request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| addr_valid | output | 1 | High during the address setup phase |
| rd_strobe | output | 1 | Read pulse |
| wr_strobe | output | 1 | Write pulse |
| cyc_drive | output | 1 | Drive of the current cycle |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |
| prefetch_en | output | 1 | Read prefetch enable |

## Verification
Cycles run with the reset timings, then with the smallest encodings (1-clock pulse, 2-clock recovery). Timing bytes with different pulse and recovery nibbles in each set show which set, which direction byte and which nibble each phase length comes from. Mixing drive number and direction shows that set selection and direction selection work apart from each other. A request that lands mid-cycle, a request in the done cycle, and a timing write made mid-cycle separate "ignored" from "queued" and "captured at acceptance" from "read live". Writes to the strap slot, and control bytes with unusual field values, show that stray bits are dropped and that each field reads back in place.

// File: rtl/pio_tmg_pkg.sv
package pio_tmg_pkg;

    localparam int NSETS = 2;
    localparam int CNT_W = 5;

    localparam logic [1:0] IDX_RD_TIM = 2'd0;
    localparam logic [1:0] IDX_WR_TIM = 2'd1;
    localparam logic [1:0] IDX_STRAP  = 2'd2;
    localparam logic [1:0] IDX_MISC   = 2'd3;

    // Upper nibble: pulse clocks - 1; lower nibble: recovery clocks - 2
    typedef struct packed {
        logic [3:0] pulse_code;
        logic [3:0] recov_code;
    } cyc_tim_t;

    typedef struct packed {
        logic       prefetch;
        logic [1:0] setup_code;
        logic [1:0] rdy_code;
        logic       set_sel;
    } misc_t;

    // Counter reload values, each equal to the phase length minus one
    typedef struct packed {
        logic [CNT_W-1:0] setup_ld;
        logic [CNT_W-1:0] pulse_ld;
        logic [CNT_W-1:0] recov_ld;
    } phase_ld_t;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_e;

    localparam cyc_tim_t TIM_SLOWEST = '{pulse_code: 4'hF, recov_code: 4'hF};
    localparam misc_t    MISC_RESET  = '{prefetch: 1'b0, setup_code: 2'd3,
                                         rdy_code: 2'd0, set_sel: 1'b0};

    function automatic phase_ld_t load_values(logic [1:0] setup_code, cyc_tim_t tim);
        phase_ld_t v;
        v.setup_ld = CNT_W'(setup_code);
        v.pulse_ld = CNT_W'(tim.pulse_code);
        v.recov_ld = CNT_W'(tim.recov_code) + CNT_W'(1);
        return v;
    endfunction

    function automatic logic [7:0] misc_to_byte(misc_t m);
        return {1'b0, m.prefetch, m.setup_code, 1'b0, m.rdy_code, m.set_sel};
    endfunction

endpackage

// File: rtl/pio_tmg_regs.sv
module pio_tmg_regs
    import pio_tmg_pkg::*;
#(
    parameter int SETS = NSETS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [1:0]            rd_addr,
    output logic [7:0]            rd_data,
    input  logic                  strap_in,
    output cyc_tim_t [SETS-1:0]   rd_tim_o,
    output cyc_tim_t [SETS-1:0]   wr_tim_o,
    output misc_t                 misc_o
);

    misc_t              misc_q;
    cyc_tim_t [SETS-1:0] rd_tim_q;
    cyc_tim_t [SETS-1:0] wr_tim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            misc_q <= MISC_RESET;
        end else if (wr_en && wr_addr == IDX_MISC) begin
            misc_q <= misc_t'({wr_data[6:4], wr_data[2:0]});
        end
    end

    for (genvar g = 0; g < SETS; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_tim_q[g] <= TIM_SLOWEST;
                wr_tim_q[g] <= TIM_SLOWEST;
            end else if (wr_en && misc_q.set_sel == 1'(g)) begin
                if (wr_addr == IDX_RD_TIM) rd_tim_q[g] <= cyc_tim_t'(wr_data);
                if (wr_addr == IDX_WR_TIM) wr_tim_q[g] <= cyc_tim_t'(wr_data);
            end
        end
    end

    always_comb begin
        case (rd_addr)
            IDX_RD_TIM: rd_data = rd_tim_q[misc_q.set_sel];
            IDX_WR_TIM: rd_data = wr_tim_q[misc_q.set_sel];
            IDX_STRAP:  rd_data = {7'd0, strap_in};
            default:    rd_data = misc_to_byte(misc_q);
        endcase
    end

    assign rd_tim_o = rd_tim_q;
    assign wr_tim_o = wr_tim_q;
    assign misc_o   = misc_q;

    // The unselected set keeps its read timing byte
    p_other_set_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == IDX_RD_TIM && misc_q.set_sel == 1'b0) |=> $stable(rd_tim_q[1]));

    // A write to the strap slot leaves every register unchanged
    p_strap_slot_ro_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == IDX_STRAP) |=> ($stable(misc_q) && $stable(rd_tim_q) && $stable(wr_tim_q)));

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_tmg_pkg::*;
#(
    parameter int SETS = NSETS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic                req_drive,
    input  logic                req_write,
    input  cyc_tim_t [SETS-1:0] rd_tim,
    input  cyc_tim_t [SETS-1:0] wr_tim,
    input  logic [1:0]          setup_code,
    output logic                addr_valid,
    output logic                rd_strobe,
    output logic                wr_strobe,
    output logic                cyc_drive,
    output logic                busy,
    output logic                done
);

    phase_e           st_q;
    logic [CNT_W-1:0] cnt_q;
    phase_ld_t        lat_q;
    logic             drv_q;
    logic             dir_wr_q;
    logic             done_q;

    cyc_tim_t  sel_tim;
    phase_ld_t new_ld;

    always_comb begin
        sel_tim = req_write ? wr_tim[req_drive] : rd_tim[req_drive];
        new_ld  = load_values(setup_code, sel_tim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= PH_IDLE;
            cnt_q    <= '0;
            lat_q    <= '0;
            drv_q    <= 1'b0;
            dir_wr_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                PH_IDLE: begin
                    if (req) begin
                        lat_q    <= new_ld;
                        cnt_q    <= new_ld.setup_ld;
                        drv_q    <= req_drive;
                        dir_wr_q <= req_write;
                        st_q     <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        cnt_q <= lat_q.pulse_ld;
                        st_q  <= PH_ACTIVE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (cnt_q == '0) begin
                        cnt_q <= lat_q.recov_ld;
                        st_q  <= PH_RECOV;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        st_q   <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign addr_valid = (st_q == PH_SETUP);
    assign rd_strobe  = (st_q == PH_ACTIVE) && !dir_wr_q;
    assign wr_strobe  = (st_q == PH_ACTIVE) && dir_wr_q;
    assign busy       = (st_q != PH_IDLE);
    assign cyc_drive  = drv_q;
    assign done       = done_q;

    // At most one of setup / read pulse / write pulse at a time
    p_one_phase_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_valid, rd_strobe, wr_strobe}));

    // A strobe always starts right after the setup phase
    p_strobe_after_setup_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_strobe || wr_strobe) |-> $past(addr_valid));

    // done follows the last recovery cycle
    p_done_after_recov_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(st_q == PH_RECOV));

    // Captured timings do not move once a cycle is under way
    p_latched_hold_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(lat_q));

    // A request while busy does not retarget the running cycle
    p_busy_drops_req_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && req) |=> $stable(cyc_drive));

endmodule

// File: rtl/pio_timing_gen.sv
module pio_timing_gen
    import pio_tmg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic [1:0] reg_raddr,
    output logic [7:0] reg_rdata,
    input  logic       strap_25mhz,
    input  logic       req,
    input  logic       req_drive,
    input  logic       req_write,
    output logic       addr_valid,
    output logic       rd_strobe,
    output logic       wr_strobe,
    output logic       cyc_drive,
    output logic       busy,
    output logic       done,
    output logic       prefetch_en
);

    cyc_tim_t [NSETS-1:0] rd_tim;
    cyc_tim_t [NSETS-1:0] wr_tim;
    misc_t                misc;

    pio_tmg_regs #(.SETS(NSETS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .rd_addr  (reg_raddr),
        .rd_data  (reg_rdata),
        .strap_in (strap_25mhz),
        .rd_tim_o (rd_tim),
        .wr_tim_o (wr_tim),
        .misc_o   (misc)
    );

    pio_phase_seq #(.SETS(NSETS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_drive  (req_drive),
        .req_write  (req_write),
        .rd_tim     (rd_tim),
        .wr_tim     (wr_tim),
        .setup_code (misc.setup_code),
        .addr_valid (addr_valid),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .cyc_drive  (cyc_drive),
        .busy       (busy),
        .done       (done)
    );

    assign prefetch_en = misc.prefetch;

    // Reset leaves the block idle with prefetch off
    p_idle_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !prefetch_en));

endmodule

// File: tb/pio_timing_gen_tb.sv
`timescale 1ns/1ps
module pio_timing_gen_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [1:0] reg_raddr;
    logic [7:0] reg_rdata;
    logic       strap_25mhz;
    logic       req, req_drive, req_write;
    logic       addr_valid, rd_strobe, wr_strobe, cyc_drive, busy, done, prefetch_en;

    always #2.5 clk = ~clk;

    pio_timing_gen u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .strap_25mhz(strap_25mhz),
        .req(req), .req_drive(req_drive), .req_write(req_write),
        .addr_valid(addr_valid), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .cyc_drive(cyc_drive), .busy(busy), .done(done), .prefetch_en(prefetch_en)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // Queue of per-cycle codes: 1 setup, 2 read pulse, 3 write pulse, 4 recovery, 5 done
    logic [7:0] m_rd [2];
    logic [7:0] m_wr [2];
    logic       m_sel, m_pref, m_drv;
    logic [1:0] m_setup, m_rdy;
    int         q[$];

    always @(posedge clk) begin : model
        int front;
        int s, p, r;
        logic [7:0] t;
        if (rst) begin
            m_rd[0] = 8'hFF; m_rd[1] = 8'hFF; m_wr[0] = 8'hFF; m_wr[1] = 8'hFF;
            m_sel = 0; m_pref = 0; m_setup = 2'd3; m_rdy = 2'd0; m_drv = 0;
            q.delete();
        end else begin
            front = (q.size() > 0) ? q[0] : 0;
            if (q.size() > 0) void'(q.pop_front());
            if (req && !(front >= 1 && front <= 4)) begin
                t = req_write ? m_wr[req_drive] : m_rd[req_drive];
                s = int'(m_setup) + 1;
                p = int'(t[7:4]) + 1;
                r = int'(t[3:0]) + 2;
                for (int i = 0; i < s; i++) q.push_back(1);
                for (int i = 0; i < p; i++) q.push_back(req_write ? 3 : 2);
                for (int i = 0; i < r; i++) q.push_back(4);
                q.push_back(5);
                m_drv = req_drive;
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_rd[m_sel] = reg_wdata;
                    2'd1: m_wr[m_sel] = reg_wdata;
                    2'd3: begin
                        m_sel = reg_wdata[0]; m_rdy = reg_wdata[2:1];
                        m_setup = reg_wdata[5:4]; m_pref = reg_wdata[6];
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic int exp_rdata(logic [1:0] idx);
        case (idx)
            2'd0: return int'(m_rd[m_sel]);
            2'd1: return int'(m_wr[m_sel]);
            2'd2: return int'(strap_25mhz);
            default: return int'({1'b0, m_pref, m_setup, 1'b0, m_rdy, m_sel});
        endcase
    endfunction

    // Per-cycle comparison, sampled just before the rising edge
    always begin
        int item;
        @(negedge clk);
        #2;
        if (!rst) begin
            item = (q.size() > 0) ? q[0] : 0;
            chk("R7", "addr_valid", int'(addr_valid), int'(item == 1));
            chk("R6", "rd_strobe",  int'(rd_strobe),  int'(item == 2));
            chk("R6", "wr_strobe",  int'(wr_strobe),  int'(item == 3));
            chk("R8", "busy",       int'(busy),       int'(item >= 1 && item <= 4));
            chk("R7", "done",       int'(done),       int'(item == 5));
            if (item >= 1 && item <= 4) chk("R6", "cyc_drive", int'(cyc_drive), int'(m_drv));
            chk("R2", "reg_rdata",  int'(reg_rdata),  exp_rdata(reg_raddr));
            chk("R11", "prefetch_en", int'(prefetch_en), int'(m_pref));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, int exp, string rq);
        @(negedge clk);
        reg_raddr = a;
        #1;
        chk(rq, "readback", int'(reg_rdata), exp);
    endtask

    task automatic run_cycle(logic d, logic w, int es, int ep, int er, string rq);
        int s, p, r, strobe_ok;
        @(negedge clk);
        req = 1'b1; req_drive = d; req_write = w;
        @(negedge clk);
        req = 1'b0;
        s = 0; p = 0; r = 0; strobe_ok = 1;
        while (addr_valid && s < 64) begin s++; @(negedge clk); end
        while ((rd_strobe || wr_strobe) && p < 64) begin
            if (rd_strobe == w) strobe_ok = 0;
            p++; @(negedge clk);
        end
        while (!done && r < 64) begin r++; @(negedge clk); end
        chk(rq, "setup clocks", s, es);
        chk(rq, "pulse clocks", p, ep);
        chk(rq, "recovery clocks", r, er);
        chk(rq, "strobe matches direction", strobe_ok, 1);
    endtask

    task automatic run_all();
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; reg_raddr = 0;
        strap_25mhz = 0; req = 0; req_drive = 0; req_write = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents and idle outputs
        rd(2'd0, 8'hFF, "R1");
        rd(2'd1, 8'hFF, "R1");
        rd(2'd3, 8'h30, "R1");
        chk("R1", "prefetch_en", int'(prefetch_en), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "addr_valid", int'(addr_valid), 0);
        run_cycle(1'b0, 1'b0, 4, 16, 17, "R1");

        // R2: program set A, then set B, then read each back
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h21);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h51);
        wr(2'd0, 8'h45);
        wr(2'd1, 8'hF0);
        rd(2'd0, 8'h45, "R2");
        rd(2'd1, 8'hF0, "R2");
        rd(2'd3, 8'h51, "R11");
        chk("R11", "prefetch_en set", int'(prefetch_en), 1);
        wr(2'd3, 8'h50);
        rd(2'd0, 8'h21, "R2");
        rd(2'd1, 8'h00, "R2");

        // R3, R4, R6: nibble decode, set and direction selection
        run_cycle(1'b0, 1'b0, 2, 3, 3, "R3");
        run_cycle(1'b0, 1'b1, 2, 1, 2, "R4");
        run_cycle(1'b1, 1'b0, 2, 5, 7, "R6");
        run_cycle(1'b1, 1'b1, 2, 16, 2, "R6");

        // R5: shared setup value applies to both drives
        wr(2'd3, 8'h30);
        run_cycle(1'b1, 1'b0, 4, 5, 7, "R5");
        run_cycle(1'b0, 1'b0, 4, 3, 3, "R5");

        // R9: timing written mid-cycle applies only to the next cycle
        fork
            run_cycle(1'b0, 1'b0, 4, 3, 3, "R9");
            begin repeat (3) @(negedge clk); wr(2'd0, 8'h12); end
        join
        run_cycle(1'b0, 1'b0, 4, 2, 4, "R9");

        // R8: request during a running cycle is dropped
        fork
            run_cycle(1'b1, 1'b1, 4, 16, 2, "R8");
            begin
                repeat (8) @(negedge clk);
                req = 1'b1; req_drive = 1'b0; req_write = 1'b0;
                @(negedge clk);
                req = 1'b0;
            end
        join
        repeat (3) begin
            @(negedge clk);
            chk("R8", "dropped request stays idle", int'(addr_valid || busy), 0);
        end

        // R8: request in the done cycle is accepted
        run_cycle(1'b0, 1'b1, 4, 1, 2, "R7");
        req = 1'b1; req_drive = 1'b1; req_write = 1'b0;
        @(negedge clk);
        req = 1'b0;
        chk("R8", "accepted on done cycle", int'(addr_valid), 1);
        while (!done) @(negedge clk);

        // R10: strap slot readback and write immunity
        strap_25mhz = 1'b1;
        rd(2'd2, 1, "R10");
        wr(2'd2, 8'hFF);
        rd(2'd3, 8'h30, "R10");
        rd(2'd0, 8'h12, "R10");
        rd(2'd1, 8'h00, "R10");
        strap_25mhz = 1'b0;
        rd(2'd2, 0, "R10");

        // R11: ready-delay code and prefetch bit, stray bits dropped
        wr(2'd3, 8'hDE);
        rd(2'd3, 8'h56, "R11");
        chk("R11", "prefetch_en on", int'(prefetch_en), 1);
        wr(2'd3, 8'h36);
        rd(2'd3, 8'h36, "R11");
        chk("R11", "prefetch_en off", int'(prefetch_en), 0);
        run_cycle(1'b0, 1'b0, 4, 2, 4, "R11");

        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule